// File: doc/BRIEF.md
# Dual-Source Ready Synchronizer with Reset Conditioning

This block gives a processor one clean bus-ready signal and one clean reset. There are two ready requests. Each comes with its own active-low address enable. A request counts only while its enable is low. The OR of the two qualified requests is then synchronized to the processor clock. A run-time select picks the depth of that synchronization. Asynchronous sources go through a rising-edge stage and then a falling-edge stage. Sources already timed to the clock go through a single falling-edge stage.

The same block conditions the board reset. An asynchronous active-low reset request is first passed through a two-flop synchronizer. It is then stretched by a hold counter, so that the active-high processor reset stays asserted for a fixed minimum number of clocks after the request is released. While the processor reset is asserted, the ready output is held low.

Top module: `ready_reset_sync`

## Requirements
- R1: `rdy_a` takes part in the ready decision only while `aen_a_n` is 0. With `aen_a_n` at 1, `rdy_a` has no effect on `ready`.
- R2: `rdy_b` takes part in the ready decision only while `aen_b_n` is 0. With `aen_b_n` at 1, `rdy_b` has no effect on `ready`.
- R3: `ready` is asserted when at least one source is qualified and high, and deasserted when neither is.
- R4: With `async_sel` = 1 (one-stage mode), a source change made after a rising edge appears on `ready` at the next falling edge.
- R5: With `async_sel` = 0 (two-stage mode), the change is captured at the next rising edge and appears on `ready` at the falling edge after that. This is one full clock later than in one-stage mode, and `ready` keeps its old value until then.
- R6: `reset_out` rises on the third rising clock edge after `res_in_n` falls.
- R7: After `res_in_n` rises between two edges, `reset_out` stays at 1 through the 17th rising edge and goes to 0 on the 18th. That is two synchronizer edges plus a hold of 16 clocks.
- R8: `ready` is 0 whenever `reset_out` is 1, whatever the sources are doing.
- R9: After `res_in_n` has been held low for several clocks, the block is in its reset state: `reset_out` = 1 and `ready` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rdy_a | input | 1 | Ready request from source A, active high |
| aen_a_n | input | 1 | Enable qualifying `rdy_a`, active low |
| rdy_b | input | 1 | Ready request from source B, active high |
| aen_b_n | input | 1 | Enable qualifying `rdy_b`, active low |
| async_sel | input | 1 | 0 selects two-stage synchronization, 1 selects one-stage |
| res_in_n | input | 1 | Asynchronous reset request, active low |
| ready | output | 1 | Synchronized ready, active high |
| reset_out | output | 1 | Conditioned processor reset, active high |

## Verification
Every source pattern is applied one time unit after a rising edge, so the bench knows exactly when each result is due:
- In one-stage mode, the expected `ready` value is due at the sample point before the next rising edge.
- In two-stage mode, it is due one cycle later. The bench also queues a check that `ready` still holds its previous value one sample earlier.

A monitor samples one time unit before each rising edge and compares against the queue in order.

The reset results are checked on exact rising-edge counts after `res_in_n` changes:
- On release, the 17th and 18th rising edges.
- On assertion, the 2nd and 3rd rising edges.

Each of these checks is sampled one time unit after its edge.

// File: rtl/rs_pkg.sv
// Package: shared types and defaults for the ready/reset synchronizer.
// Assumes: nothing beyond IEEE 1800-2017.
package rs_pkg;
    typedef enum logic {
        SYNC_TWO = 1'b0,   // rising-edge stage followed by falling-edge stage
        SYNC_ONE = 1'b1    // single falling-edge stage
    } sync_mode_e;

    localparam int unsigned RS_NUM_SRC     = 2;
    localparam int unsigned RS_HOLD_CLOCKS = 16;
    localparam int unsigned RS_SYNC_DEPTH  = 2;
endpackage

// File: rtl/ready_qualify.sv
// Module: ready_qualify
// Combines NUM_SRC ready requests. Each request is masked by its own
// active-low enable, and the masked terms are OR-ed into one raw ready.
// Assumes: inputs may be asynchronous; the result is synchronized downstream.
module ready_qualify #(
    parameter int unsigned NUM_SRC = 2
) (
    input  logic [NUM_SRC-1:0] rdy,
    input  logic [NUM_SRC-1:0] aen_n,
    output logic               raw_ready
);
    logic [NUM_SRC-1:0] gated;

    // One gate per source: the request counts only while its enable is low.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_gate
        assign gated[i] = rdy[i] & ~aen_n[i];
    end

    // Any qualified source raises the raw ready.
    always_comb begin
        raw_ready = |gated;
    end
endmodule

// File: rtl/ready_sync.sv
// Module: ready_sync
// Synchronizes the raw ready to the processor clock.
// Two-stage mode: a rising-edge flop feeds a falling-edge flop.
// One-stage mode: the falling-edge flop samples the raw ready directly.
// Assumes: the mode is quasi-static. sync_rst_n is synchronous and active
// low, and comes from the reset conditioner.
module ready_sync (
    input  logic              clk,
    input  logic              sync_rst_n,
    input  rs_pkg::sync_mode_e mode,
    input  logic              raw_ready,
    output logic              ready
);
    import rs_pkg::*;

    logic stage_rise;
    logic stage_fall;

    // First stage: capture the raw ready on the rising edge.
    always_ff @(posedge clk) begin
        if (!sync_rst_n) stage_rise <= 1'b0;
        else             stage_rise <= raw_ready;
    end

    // Output stage: falling-edge capture, with the source chosen by the mode.
    always_ff @(negedge clk) begin
        if (!sync_rst_n)            stage_fall <= 1'b0;
        else if (mode == SYNC_ONE)  stage_fall <= raw_ready;
        else                        stage_fall <= stage_rise;
    end

    // Output gate: ready is forced low while reset is held.
    always_comb begin
        ready = stage_fall & sync_rst_n;
    end

    // R8: once reset is seen at a falling edge, the output flop is clear
    // by the next falling edge.
    assert_stage_clear_R8: assert property (@(negedge clk)
        !sync_rst_n |=> !stage_fall);

    // R5: in two-stage mode the output flop takes the rising-edge stage.
    assert_two_stage_path_R5: assert property (@(negedge clk)
        (sync_rst_n && mode == SYNC_TWO) |=> (stage_fall == $past(stage_rise)));

    // R4: in one-stage mode the output flop takes the raw ready directly.
    assert_one_stage_path_R4: assert property (@(negedge clk)
        (sync_rst_n && mode == SYNC_ONE) |=> (stage_fall == $past(raw_ready)));
endmodule

// File: rtl/reset_cond.sv
// Module: reset_cond
// Turns an asynchronous active-low reset request into an active-high reset.
// The request goes through a SYNC_DEPTH flop chain. The reset is then held
// for HOLD_CLOCKS rising edges after the synchronized request goes high.
// Assumes: SYNC_DEPTH >= 2 and HOLD_CLOCKS >= 2.
module reset_cond #(
    parameter int unsigned SYNC_DEPTH  = 2,
    parameter int unsigned HOLD_CLOCKS = 16
) (
    input  logic clk,
    input  logic res_in_n,
    output logic reset_out
);
    localparam int unsigned CW = $clog2(HOLD_CLOCKS);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CLOCKS - 1);

    logic [SYNC_DEPTH-1:0] chain;
    logic                  sync_n;
    logic [CW-1:0]         hold_cnt;
    logic                  rst_q;

    // Synchronizer chain for the asynchronous reset request.
    always_ff @(posedge clk) begin
        chain <= {chain[SYNC_DEPTH-2:0], res_in_n};
    end

    assign sync_n = chain[SYNC_DEPTH-1];

    // Hold counter: clear on request, count while held, release at the last count.
    always_ff @(posedge clk) begin
        if (!sync_n) begin
            hold_cnt <= '0;
            rst_q    <= 1'b1;
        end else if (rst_q) begin
            if (hold_cnt == LAST) rst_q <= 1'b0;
            else                  hold_cnt <= hold_cnt + 1'b1;
        end
    end

    assign reset_out = rst_q;

    // Checker counter: consecutive rising edges with the synchronized request high.
    logic [CW:0] chk_high;
    always_ff @(posedge clk) begin
        if (!sync_n)                         chk_high <= '0;
        else if (chk_high != (CW+1)'(HOLD_CLOCKS)) chk_high <= chk_high + 1'b1;
    end

    // R6: a synchronized low request asserts the reset on the next edge.
    assert_reset_follows_req_R6: assert property (@(posedge clk)
        !sync_n |=> reset_out);

    // R7: the reset is released only after the full hold window.
    assert_min_hold_R7: assert property (@(posedge clk)
        $fell(reset_out) |-> (chk_high == (CW+1)'(HOLD_CLOCKS)));
endmodule

// File: rtl/ready_reset_sync.sv
// Module: ready_reset_sync (top)
// Qualifies two ready sources, synchronizes the result in a selectable
// depth, and conditions the processor reset.
// Assumes: async_sel changes only when the sources are quiet.
module ready_reset_sync #(
    parameter int unsigned HOLD_CLOCKS = rs_pkg::RS_HOLD_CLOCKS,
    parameter int unsigned SYNC_DEPTH  = rs_pkg::RS_SYNC_DEPTH
) (
    input  logic clk,
    input  logic rdy_a,
    input  logic aen_a_n,
    input  logic rdy_b,
    input  logic aen_b_n,
    input  logic async_sel,
    input  logic res_in_n,
    output logic ready,
    output logic reset_out
);
    import rs_pkg::*;

    localparam int unsigned NSRC = RS_NUM_SRC;

    logic       raw_ready;
    sync_mode_e mode;

    // Select decode: a high select means the sources are already synchronous.
    always_comb begin
        mode = async_sel ? SYNC_ONE : SYNC_TWO;
    end

    ready_qualify #(.NUM_SRC(NSRC)) u_qualify (
        .rdy       ({rdy_b, rdy_a}),
        .aen_n     ({aen_b_n, aen_a_n}),
        .raw_ready (raw_ready)
    );

    reset_cond #(.SYNC_DEPTH(SYNC_DEPTH), .HOLD_CLOCKS(HOLD_CLOCKS)) u_reset (
        .clk       (clk),
        .res_in_n  (res_in_n),
        .reset_out (reset_out)
    );

    ready_sync u_sync (
        .clk        (clk),
        .sync_rst_n (~reset_out),
        .mode       (mode),
        .raw_ready  (raw_ready),
        .ready      (ready)
    );
endmodule

// File: tb/tb_ready_reset_sync.sv
module tb_ready_reset_sync;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = CLK_PERIOD / 2;

    logic clk = 1'b0;
    logic rdy_a = 1'b0, aen_a_n = 1'b1, rdy_b = 1'b0, aen_b_n = 1'b1;
    logic async_sel = 1'b1, res_in_n = 1'b0;
    logic ready, reset_out;

    ready_reset_sync dut (
        .clk(clk), .rdy_a(rdy_a), .aen_a_n(aen_a_n), .rdy_b(rdy_b),
        .aen_b_n(aen_b_n), .async_sel(async_sel), .res_in_n(res_in_n),
        .ready(ready), .reset_out(reset_out)
    );

    always #(HALF) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_err = 0;

    typedef struct {
        int    due;
        logic  exp;
        string req;
    } item_t;
    item_t sb[$];

    logic prev_exp = 1'b0;
    logic prev_sel = 1'b1;

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
        end
    endtask

    // Driver: apply a pattern after a rising edge and queue the expected ready.
    task automatic apply(input logic ra, input logic an_a, input logic rb,
                         input logic an_b, input logic sel, input string req);
        logic e;
        int lat;
        item_t it;
        @(posedge clk); #1;
        rdy_a = ra; aen_a_n = an_a; rdy_b = rb; aen_b_n = an_b; async_sel = sel;
        e = (ra & ~an_a) | (rb & ~an_b);
        lat = sel ? 0 : 1;
        if (lat == 1) begin
            it.due = cyc; it.exp = prev_exp; it.req = {req, " early"};
            sb.push_back(it);
        end
        it.due = cyc + lat; it.exp = e; it.req = req;
        sb.push_back(it);
        prev_exp = e;
        prev_sel = sel;
        repeat (2) @(posedge clk);
    endtask

    // Monitor: sample just before each rising edge and compare what is due.
    initial begin
        forever begin
            @(negedge clk); #(HALF - 1);
            while (sb.size() > 0 && sb[0].due <= cyc) begin
                item_t it;
                it = sb.pop_front();
                if (it.due != cyc) begin
                    n_chk++; n_err++;
                    $display("FAIL %s actual=missed expected=due %0d", it.req, it.due);
                end else begin
                    chk(it.req, ready, it.exp);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_err++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        // Reset state, with source A requesting ready throughout.
        rdy_a = 1'b1; aen_a_n = 1'b0; async_sel = 1'b1; res_in_n = 1'b0;
        repeat (6) @(posedge clk); #1;
        chk("R9 reset_out", reset_out, 1'b1);
        chk("R9 ready", ready, 1'b0);

        // Release: the 17th edge is still in reset, the 18th releases it.
        @(posedge clk); #1; res_in_n = 1'b1;
        repeat (17) @(posedge clk); #1;
        chk("R7 held at edge 17", reset_out, 1'b1);
        chk("R8 ready forced low", ready, 1'b0);
        @(posedge clk); #1;
        chk("R7 released at edge 18", reset_out, 1'b0);
        @(negedge clk); #1;
        chk("R4 first falling edge after release", ready, 1'b1);
        prev_exp = 1'b1; prev_sel = 1'b1;

        // One-stage patterns.
        apply(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R3 none");
        apply(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R1 gated a");
        apply(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R1 enabled a");
        apply(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R2 gated b");
        apply(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R2 enabled b");
        apply(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R3 both");
        apply(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, "R3 both gated");
        apply(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, "R3 a only");

        // Two-stage patterns.
        apply(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R5 fall");
        apply(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R5 rise via b");
        apply(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R5 gated");
        apply(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R5 rise via a");
        apply(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R1 two-stage gate");
        apply(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R4 back to one-stage");
        repeat (3) @(posedge clk);

        // Reassert reset while ready is high.
        @(posedge clk); #1; res_in_n = 1'b0;
        repeat (2) @(posedge clk); #1;
        chk("R6 not yet at edge 2", reset_out, 1'b0);
        @(posedge clk); #1;
        chk("R6 asserted at edge 3", reset_out, 1'b1);
        chk("R8 ready drops with reset", ready, 1'b0);
        repeat (2) @(posedge clk);

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule